// File: doc/BRIEF.md
# Board Interrupt Aggregator

This block gathers sixteen external interrupt request lines on a board-control device and merges them into a single active-low, level-sensitive request for a host GPIO pin. Each source is brought into the local clock domain through a two-flop synchroniser. A rising edge on a source latches that source's pending bit, but only while the source's enable bit is set. A separate per-source pass bit decides whether a pending source may pull the host line low.

Software drives the block through a small 16-bit register bus. Enable bits and pass bits each have their own write-one-to-set and write-one-to-clear registers, so that zero bits never disturb other sources. Pending bits are read as one vector and are acknowledged by writing ones to the same location. A read-only identity word carries a board code and a revision number, and the host driver checks that number before it trusts the block.

Top module: `brd_irq_agg`

## Requirements
- R1: After reset the enable, pass and pending vectors are all zero and `irq_n` is high.
- R2: A write to offset 0x4 sets every enable bit whose write-data bit is 1. A write to offset 0x6 clears every enable bit whose write-data bit is 1. Zero bits leave enables unchanged, and a read of either offset returns the enable vector.
- R3: Pass bits work the same way through offset 0x8 (set) and offset 0xA (clear), and a read of either offset returns the pass vector. A pass bit of 1 lets the source reach the output.
- R4: Bit n of the pending vector latches three clock edges after source n rises, counted from the first edge that samples the new level, provided enable n is set. A source held high does not latch again after it is acknowledged.
- R5: A write to offset 0x2 clears every pending bit whose write-data bit is 1, and zero bits have no effect. If a new rising edge on a bit lands in the same cycle as its acknowledge, the bit stays pending.
- R6: `irq_n` is low exactly while some bit is pending, enabled and passed at the same time.
- R7: A source whose enable bit is clear never latches as pending. Clearing the enable bit of a pending source releases the output but keeps the pending bit.
- R8: A read of offset 0x0 returns 0xB2 in bits 15:8, zero in bits 7:4 and revision 4 in bits 3:0. Writes to that offset change nothing.
- R9: `bus_rdata` is zero when `bus_re` is low and when the read address is not one of the six defined offsets.
- R10: Writing 0xFFFF to offsets 0x6, 0xA and 0x2 returns the block to the reset state. Afterwards source activity leaves `irq_n` high and the pending vector at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | 16 | Asynchronous interrupt sources, bit n is source n |
| bus_addr | input | 4 | Byte offset of the register |
| bus_wdata | input | 16 | Write data |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_re | input | 1 | Read strobe; read data is combinational |
| bus_rdata | output | 16 | Read data, zero when not reading |
| irq_n | output | 1 | Active-low level request to the host |

## Verification
The sources are driven in several ways: one line rising alone, a line held high across an acknowledge, a line rising on a disabled source, and a wide pattern that raises several lines at once while others are already high. Together these separate edge capture from level capture, and the enable gate from the pass gate. One case lines up a rising edge exactly with its acknowledge write, which shows whether the new event or the clear takes priority. A behavioural model in the bench follows every clock cycle, so any latency error on the three-stage path from source to pending shows up as a mismatch in `irq_n` or in read data.

// File: rtl/brd_irq_pkg.sv
package brd_irq_pkg;
    localparam int unsigned ADDR_W = 4;

    typedef enum logic [ADDR_W-1:0] {
        OFF_IDENT = 4'h0,
        OFF_STAT  = 4'h2,
        OFF_ENSET = 4'h4,
        OFF_ENCLR = 4'h6,
        OFF_PSET  = 4'h8,
        OFF_PCLR  = 4'hA
    } reg_off_e;
endpackage

// File: rtl/brd_irq_sync.sv
module brd_irq_sync #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] in_i,
    output logic [W-1:0] rise_o
);
    typedef struct packed {
        logic [W-1:0] meta;
        logic [W-1:0] stab;
        logic [W-1:0] prev;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d.meta = in_i;
        st_d.stab = st_q.meta;
        st_d.prev = st_q.stab;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rise_o = st_q.stab & ~st_q.prev;
endmodule

// File: rtl/brd_irq_regs.sv
module brd_irq_regs
    import brd_irq_pkg::*;
#(
    parameter int unsigned W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [W-1:0]      rise_i,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [W-1:0]      wdata_i,
    output logic [W-1:0]      en_o,
    output logic [W-1:0]      pass_o,
    output logic [W-1:0]      pend_o
);
    typedef struct packed {
        logic [W-1:0] en;
        logic [W-1:0] pass;
        logic [W-1:0] pend;
    } ctl_t;

    ctl_t st_d, st_q;

    always_comb begin
        logic [W-1:0] en_set, en_clr, p_set, p_clr, ack;
        en_set = '0;
        en_clr = '0;
        p_set  = '0;
        p_clr  = '0;
        ack    = '0;
        if (we_i) begin
            case (addr_i)
                OFF_ENSET: en_set = wdata_i;
                OFF_ENCLR: en_clr = wdata_i;
                OFF_PSET:  p_set  = wdata_i;
                OFF_PCLR:  p_clr  = wdata_i;
                OFF_STAT:  ack    = wdata_i;
                default:   ;
            endcase
        end
        st_d.en   = (st_q.en | en_set) & ~en_clr;
        st_d.pass = (st_q.pass | p_set) & ~p_clr;
        st_d.pend = (st_q.pend & ~ack) | (rise_i & st_q.en);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign en_o   = st_q.en;
    assign pass_o = st_q.pass;
    assign pend_o = st_q.pend;
endmodule

// File: rtl/brd_irq_agg.sv
module brd_irq_agg
    import brd_irq_pkg::*;
#(
    parameter int unsigned NSRC       = 16,
    parameter logic [7:0]  BOARD_CODE = 8'hB2,
    parameter logic [3:0]  REVISION   = 4'd4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   src_i,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [NSRC-1:0]   bus_wdata,
    input  logic              bus_we,
    input  logic              bus_re,
    output logic [NSRC-1:0]   bus_rdata,
    output logic              irq_n
);
    localparam logic [NSRC-1:0] IDENT_WORD = NSRC'({BOARD_CODE, 4'h0, REVISION});

    logic [NSRC-1:0] rise_vec;
    logic [NSRC-1:0] en_vec;
    logic [NSRC-1:0] pass_vec;
    logic [NSRC-1:0] pend_vec;

    brd_irq_sync #(.W(NSRC)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .in_i   (src_i),
        .rise_o (rise_vec)
    );

    brd_irq_regs #(.W(NSRC)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .rise_i  (rise_vec),
        .we_i    (bus_we),
        .addr_i  (bus_addr),
        .wdata_i (bus_wdata),
        .en_o    (en_vec),
        .pass_o  (pass_vec),
        .pend_o  (pend_vec)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_re) begin
            case (bus_addr)
                OFF_IDENT:           bus_rdata = IDENT_WORD;
                OFF_STAT:            bus_rdata = pend_vec;
                OFF_ENSET, OFF_ENCLR: bus_rdata = en_vec;
                OFF_PSET, OFF_PCLR:  bus_rdata = pass_vec;
                default:             bus_rdata = '0;
            endcase
        end
    end

    assign irq_n = ~|(pend_vec & en_vec & pass_vec);
endmodule

// File: rtl/brd_irq_agg_chk.sv
module brd_irq_agg_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        bus_we,
    input logic        bus_re,
    input logic [3:0]  bus_addr,
    input logic [15:0] bus_wdata,
    input logic [15:0] bus_rdata,
    input logic        irq_n,
    input logic [15:0] en_vec,
    input logic [15:0] pass_vec,
    input logic [15:0] pend_vec,
    input logic [15:0] rise_vec
);
    p_en_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == 4'h4) |=> ((en_vec & $past(bus_wdata)) == $past(bus_wdata)));

    p_en_clr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == 4'h6) |=> ((en_vec & $past(bus_wdata)) == 16'h0));

    p_pass_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == 4'h8) |=> ((pass_vec & $past(bus_wdata)) == $past(bus_wdata)));

    p_pass_clr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == 4'hA) |=> ((pass_vec & $past(bus_wdata)) == 16'h0));

    p_ack_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == 4'h2) |=> ((pend_vec & $past(bus_wdata) & ~$past(rise_vec)) == 16'h0));

    p_no_latch_disabled_r7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pend_vec & ~$past(pend_vec) & ~$past(en_vec)) == 16'h0));

    p_quiet_when_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((en_vec & pass_vec) == 16'h0) |-> irq_n);

    p_idle_rdata_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_re |-> (bus_rdata == 16'h0));
endmodule

bind brd_irq_agg brd_irq_agg_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (bus_we),
    .bus_re    (bus_re),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_n     (irq_n),
    .en_vec    (en_vec),
    .pass_vec  (pass_vec),
    .pend_vec  (pend_vec),
    .rise_vec  (rise_vec)
);

// File: tb/sim_brd_irq_agg.sv
module sim_brd_irq_agg;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] src_i = '0;
    logic [3:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic        bus_re = 1'b0;
    logic [15:0] bus_rdata;
    logic        irq_n;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    localparam logic [15:0] ID_EXP = 16'hB204;

    always #5 clk = ~clk;

    brd_irq_agg u0 (
        .clk(clk), .rst_n(rst_n), .src_i(src_i), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_we(bus_we), .bus_re(bus_re),
        .bus_rdata(bus_rdata), .irq_n(irq_n)
    );

    // behavioural reference: shift history of sampled sources plus state words
    logic [15:0] hist[$];
    logic [15:0] m_en = '0, m_pass = '0, m_pend = '0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hist = '{16'h0, 16'h0, 16'h0};
            m_en = '0; m_pass = '0; m_pend = '0;
        end else begin
            logic [15:0] newer, older, ev, ack;
            newer = hist[1];
            older = hist[2];
            ev = newer & ~older;
            ack = (bus_we && bus_addr == 4'h2) ? bus_wdata : 16'h0;
            m_pend = (m_pend & ~ack) | (ev & m_en);
            if (bus_we && bus_addr == 4'h4) m_en = m_en | bus_wdata;
            if (bus_we && bus_addr == 4'h6) m_en = m_en & ~bus_wdata;
            if (bus_we && bus_addr == 4'h8) m_pass = m_pass | bus_wdata;
            if (bus_we && bus_addr == 4'hA) m_pass = m_pass & ~bus_wdata;
            hist.push_front(src_i);
            void'(hist.pop_back());
        end
    end

    function automatic logic [15:0] exp_rd();
        if (!bus_re) return 16'h0;
        case (bus_addr)
            4'h0: return ID_EXP;
            4'h2: return m_pend;
            4'h4, 4'h6: return m_en;
            4'h8, 4'hA: return m_pass;
            default: return 16'h0;
        endcase
    endfunction

    task automatic check(string req, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // per-cycle comparison against the model (R6 output, R9 read data)
    always begin
        @(negedge clk);
        #1;
        if (rst_n && !done) begin
            check("R6 model irq_n", {15'h0, irq_n}, {15'h0, ((m_pend & m_en & m_pass) == 16'h0)});
            check("R9 model rdata", bus_rdata, exp_rd());
        end
    end

    task automatic wr(logic [3:0] a, logic [15:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(logic [3:0] a, logic [15:0] exp, string req);
        @(negedge clk);
        bus_re = 1'b1; bus_addr = a;
        #2;
        check(req, bus_rdata, exp);
        @(negedge clk);
        bus_re = 1'b0;
    endtask

    task automatic irq_is(logic exp, string req);
        @(negedge clk);
        #2;
        check(req, {15'h0, irq_n}, {15'h0, exp});
    endtask

    task automatic settle();
        repeat (5) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 / R8
        irq_is(1'b1, "R1 irq_n after reset");
        rd(4'h2, 16'h0, "R1 pending after reset");
        rd(4'h4, 16'h0, "R1 enable after reset");
        rd(4'hA, 16'h0, "R1 pass after reset");
        rd(4'h0, ID_EXP, "R8 identity word");
        // R2 enable set/clear
        wr(4'h4, 16'h0005); rd(4'h4, 16'h0005, "R2 enable set");
        rd(4'h6, 16'h0005, "R2 enable read at clear offset");
        wr(4'h6, 16'h0001); rd(4'h4, 16'h0004, "R2 enable clear");
        wr(4'h4, 16'h0003); rd(4'h6, 16'h0007, "R2 zero bits keep enables");
        // R3 pass set/clear
        wr(4'h8, 16'h00F0); rd(4'h8, 16'h00F0, "R3 pass set");
        wr(4'hA, 16'h0030); rd(4'hA, 16'h00C0, "R3 pass clear");
        // R4 latch on source 2, masked from output
        @(negedge clk); src_i = 16'h0004;
        settle();
        rd(4'h2, 16'h0004, "R4 pending latched");
        irq_is(1'b1, "R6 pass gate holds irq_n high");
        wr(4'h8, 16'h0004);
        irq_is(1'b0, "R6 irq_n low when pending enabled passed");
        // R7 disabled source 8
        @(negedge clk); src_i = 16'h0104;
        settle();
        rd(4'h2, 16'h0004, "R7 disabled source not latched");
        // R5 acknowledge
        wr(4'h2, 16'h0000); rd(4'h2, 16'h0004, "R5 zero ack keeps pending");
        wr(4'h2, 16'h0004); rd(4'h2, 16'h0000, "R5 ack clears pending");
        irq_is(1'b1, "R6 irq_n released after ack");
        settle();
        rd(4'h2, 16'h0000, "R4 held level does not re-latch");
        // R7 enable gates output but keeps pending
        @(negedge clk); src_i = 16'h0100;
        settle();
        @(negedge clk); src_i = 16'h0104;
        settle();
        irq_is(1'b0, "R4 second edge asserts irq_n");
        wr(4'h6, 16'h0004);
        irq_is(1'b1, "R7 disable releases output");
        rd(4'h2, 16'h0004, "R7 pending kept while disabled");
        wr(4'h4, 16'h0004);
        irq_is(1'b0, "R7 re-enable reasserts output");
        // R5 same-cycle event and acknowledge
        @(negedge clk); src_i = 16'h0100;
        settle();
        wr(4'h2, 16'h0004);
        rd(4'h2, 16'h0000, "R5 cleared before race");
        @(negedge clk); src_i = 16'h0104;   // sampled at edge A
        @(negedge clk);                      // edge B makes the event
        bus_we = 1'b1; bus_addr = 4'h2; bus_wdata = 16'h0004; // ack at edge C
        @(negedge clk);
        bus_we = 1'b0; bus_wdata = '0;
        rd(4'h2, 16'h0004, "R5 new event beats acknowledge");
        // multi-source pattern
        wr(4'h4, 16'hFFFF); wr(4'h8, 16'hFFFF); wr(4'h2, 16'hFFFF);
        @(negedge clk); src_i = 16'hF00F;
        settle();
        rd(4'h2, 16'hF00B, "R4 multiple rising sources");
        // R8 / R9
        wr(4'h0, 16'hFFFF); rd(4'h0, ID_EXP, "R8 identity write ignored");
        rd(4'hC, 16'h0000, "R9 unmapped offset");
        rd(4'h3, 16'h0000, "R9 odd offset");
        // R10 clear-all
        wr(4'h6, 16'hFFFF); wr(4'hA, 16'hFFFF); wr(4'h2, 16'hFFFF);
        rd(4'h2, 16'h0000, "R10 pending cleared");
        rd(4'h4, 16'h0000, "R10 enables cleared");
        rd(4'h8, 16'h0000, "R10 pass cleared");
        irq_is(1'b1, "R10 irq_n high");
        @(negedge clk); src_i = 16'h0000;
        settle();
        @(negedge clk); src_i = 16'hFFFF;
        settle();
        rd(4'h2, 16'h0000, "R10 activity ignored after clear-all");
        irq_is(1'b1, "R10 irq_n stays high");
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule